// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block tells whether a NOR flash has finished an embedded program or erase operation. Once the command sequence has been issued elsewhere, the poller is launched with the device address to watch and a timeout count. It then reads that address in back-to-back pairs over a simple read port and inspects two status bits in the returned words.

While a program or erase is in progress, the device flips its toggle bit (bit 6) on every read. When two reads in a row return the same toggle bit, the operation is finished. Bit 5 is the device's time-limit flag. When it is set in the first read of a toggling pair, the poller does not trust that pair alone. It takes a confirming pair, and it reports an error only if the toggle bit still flips and the flag is still set. A cycle counter that starts at launch bounds the whole wait.

The run ends with a one-cycle done pulse and a 2-bit result code. The block then goes back to idle and is ready for the next launch.

Top module: `tbit_poller`

## Requirements
- R1: After reset the block is idle: `busy_o`, `rd_req_o` and `done_o` are all low.
- R2: A start in idle captures `addr_i` and `limit_i`. Every read then goes to the captured address, and each read is one single-cycle `rd_req_o` pulse. The next request is issued only after `rd_valid_i` has returned the previous word.
- R3: When bit 6 is equal in the two words of a pair, the run ends with result 2'b00 (success).
- R4: When bit 6 differs between the two words and bit 5 of the first word is clear, a new pair of reads follows. Bit 5 of the second word plays no part in this decision.
- R5: When bit 6 differs and bit 5 of the first word is set, a confirming pair is read. If bit 6 is equal in the confirming pair, the result is 2'b00. If bit 6 still differs and bit 5 of the confirming pair's first word is set, the result is 2'b01 (error).
- R6: A confirming pair whose bit 6 differs while bit 5 of its first word is clear returns the block to ordinary polling, without reporting an error.
- R7: A launch with `limit_i` equal to zero issues no read. It raises `done_o` with result 2'b10 (timeout) in the cycle after the start.
- R8: A `limit_i` of all ones disables the timeout, so polling continues until success or error.
- R9: For any other limit, a cycle counter is cleared at launch and is never cleared between pairs. The counter is compared when a toggling pair yields neither success nor error. Result 2'b10 is reported once the count is strictly greater than the limit.
- R10: `done_o` is high for exactly one cycle per run, and `result_o` then holds 2'b00, 2'b01 or 2'b10, never 2'b11.
- R11: A start received while the block is busy is ignored: the address, the limit and the run in progress are unchanged.
- R12: Bits of the returned word other than bits 5 and 6 have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch request, accepted only while idle |
| addr_i | input | AW | Flash address to poll |
| limit_i | input | TW | Timeout in cycles; 0 = immediate timeout, all ones = no timeout |
| rd_req_o | output | 1 | Single-cycle read request |
| rd_addr_o | output | AW | Address of the read |
| rd_data_i | input | DW | Word returned by the flash |
| rd_valid_i | input | 1 | `rd_data_i` is valid this cycle |
| busy_o | output | 1 | A poll run is in progress |
| done_o | output | 1 | One-cycle pulse marking the end of a run |
| result_o | output | 2 | 00 success, 01 error, 10 timeout |

## Verification
The read responder replays scripted word sequences, and the expected result and read count are worked out from the requirements.

- **Bit 6 alone:** a stable first pair, a pair whose other bits all differ, and toggling pairs that settle later. These separate a decision on bit 6 from one on any other bit.
- **Bit 5 placement:** the flag set only in the second word, set in the first word with a calm confirmation, set with a persisting toggle, and cleared during the confirmation. These show which word's flag is consulted and when an error is allowed.
- **Timeout boundaries:** limits of 0, 5, 6, 12 and all ones against an endless toggle. These separate "greater than" from "greater or equal", and a counter kept from launch from one restarted on every pair.
- **Start while busy:** a start pulse injected mid-run must not disturb the address or the outcome.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

    typedef enum logic [1:0] {
        RES_OK  = 2'b00,
        RES_ERR = 2'b01,
        RES_TMO = 2'b10
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_A,
        ST_WAIT_A,
        ST_REQ_B,
        ST_WAIT_B,
        ST_DECIDE
    } poll_state_e;

    typedef enum logic [1:0] {
        VD_DONE,
        VD_FAIL,
        VD_AGAIN,
        VD_CONFIRM
    } verdict_e;

endpackage

// File: rtl/tbit_timer.sv
module tbit_timer
    import tbit_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [TW-1:0] limit_i,
    input  logic          run_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] NO_LIMIT = {TW{1'b1}};

    logic [TW-1:0] elapsed_d, elapsed_q;
    logic [TW-1:0] limit_d, limit_q;

    always_comb begin
        elapsed_d = elapsed_q;
        limit_d   = limit_q;
        if (launch_i) begin
            elapsed_d = '0;
            limit_d   = limit_i;
        end else if (run_i && elapsed_q != NO_LIMIT) begin
            elapsed_d = elapsed_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            limit_q   <= '0;
        end else begin
            elapsed_q <= elapsed_d;
            limit_q   <= limit_d;
        end
    end

    assign expired_o = (limit_q != NO_LIMIT) && (elapsed_q > limit_q);

    AST_ELAPSED_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && !$past(launch_i)) |-> (elapsed_q >= $past(elapsed_q))) // R9
        else $error("elapsed counter restarted mid-run");

endmodule

// File: rtl/tbit_judge.sv
module tbit_judge
    import tbit_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TOG_BIT = 6,
    parameter int LIM_BIT = 5
) (
    input  logic [DW-1:0] first_i,
    input  logic [DW-1:0] second_i,
    input  logic          confirm_i,
    output verdict_e      verdict_o
);
    logic toggled;
    logic flagged;
    logic unused_bits;

    assign toggled     = first_i[TOG_BIT] ^ second_i[TOG_BIT];
    assign flagged     = first_i[LIM_BIT];
    assign unused_bits = ^{first_i, second_i};

    always_comb begin
        if (!toggled)        verdict_o = VD_DONE;
        else if (!flagged)   verdict_o = VD_AGAIN;
        else if (confirm_i)  verdict_o = VD_FAIL;
        else                 verdict_o = VD_CONFIRM;
    end

    always_comb begin
        if (verdict_o == VD_FAIL)
            AST_FAIL_NEEDS_FLAG: assert (flagged && toggled); // R5
    end

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
    import tbit_pkg::*;
#(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int TW      = 16,
    parameter int TOG_BIT = 6,
    parameter int LIM_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] limit_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i,
    input  logic          rd_valid_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o
);
    typedef struct packed {
        poll_state_e   st;
        logic [AW-1:0] addr;
        logic [DW-1:0] first;
        logic [DW-1:0] second;
        logic          confirm;
        logic          done;
        res_e          res;
    } ctx_t;

    ctx_t     ctx_d, ctx_q;
    verdict_e verdict;
    logic     expired;
    logic     launch;
    logic     running;

    assign launch  = (ctx_q.st == ST_IDLE) && start_i && (limit_i != '0);
    assign running = (ctx_q.st != ST_IDLE);

    tbit_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .limit_i   (limit_i),
        .run_i     (running),
        .expired_o (expired)
    );

    tbit_judge #(.DW(DW), .TOG_BIT(TOG_BIT), .LIM_BIT(LIM_BIT)) u_judge (
        .first_i   (ctx_q.first),
        .second_i  (ctx_q.second),
        .confirm_i (ctx_q.confirm),
        .verdict_o (verdict)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (limit_i == '0) begin
                        ctx_d.done = 1'b1;
                        ctx_d.res  = RES_TMO;
                    end else begin
                        ctx_d.addr    = addr_i;
                        ctx_d.confirm = 1'b0;
                        ctx_d.st      = ST_REQ_A;
                    end
                end
            end
            ST_REQ_A:  ctx_d.st = ST_WAIT_A;
            ST_WAIT_A: begin
                if (rd_valid_i) begin
                    ctx_d.first = rd_data_i;
                    ctx_d.st    = ST_REQ_B;
                end
            end
            ST_REQ_B:  ctx_d.st = ST_WAIT_B;
            ST_WAIT_B: begin
                if (rd_valid_i) begin
                    ctx_d.second = rd_data_i;
                    ctx_d.st     = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (verdict == VD_DONE) begin
                    ctx_d.done = 1'b1;
                    ctx_d.res  = RES_OK;
                    ctx_d.st   = ST_IDLE;
                end else if (verdict == VD_FAIL) begin
                    ctx_d.done = 1'b1;
                    ctx_d.res  = RES_ERR;
                    ctx_d.st   = ST_IDLE;
                end else if (expired) begin
                    ctx_d.done = 1'b1;
                    ctx_d.res  = RES_TMO;
                    ctx_d.st   = ST_IDLE;
                end else begin
                    ctx_d.confirm = (verdict == VD_CONFIRM);
                    ctx_d.st      = ST_REQ_A;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, addr: '0, first: '0, second: '0,
                       confirm: 1'b0, done: 1'b0, res: RES_OK};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign rd_req_o  = (ctx_q.st == ST_REQ_A) || (ctx_q.st == ST_REQ_B);
    assign rd_addr_o = ctx_q.addr;
    assign busy_o    = running;
    assign done_o    = ctx_q.done;
    assign result_o  = ctx_q.res;

    AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o) // R2
        else $error("read request longer than one cycle");

    AST_STABLE_IS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_DECIDE && ctx_q.first[TOG_BIT] == ctx_q.second[TOG_BIT])
        |=> (done_o && result_o == RES_OK)) // R3
        else $error("stable toggle bit did not end in success");

    AST_ERR_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == RES_ERR) |-> $past(ctx_q.confirm)) // R5
        else $error("error reported without a confirming pair");

    AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && limit_i == '0) |=> (done_o && result_o == RES_TMO && !busy_o)) // R7
        else $error("zero limit did not time out at once");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) // R10
        else $error("done held longer than one cycle");

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o != 2'b11)) // R10
        else $error("illegal result code");

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)) // R11
        else $error("address changed during a run");

endmodule

// File: tb/sim_tbit_poller.sv
`timescale 1ns/1ps
module sim_tbit_poller;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int TW = 16;
    localparam logic [AW-1:0] ADDR = 24'h01_2A46;
    localparam logic [AW-1:0] ALT  = 24'h3C_0001;

    typedef struct packed {
        logic [0:7][15:0] rd;
        logic [15:0]      lim;
        logic [1:0]       res;
        logic [3:0]       nrd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{'{16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b00, 4'd2},
        '{'{16'h00BF,16'h0013,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b00, 4'd2},
        '{'{16'h0040,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b00, 4'd4},
        '{'{16'h0040,16'h0020,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b00, 4'd4},
        '{'{16'h0060,16'h0000,16'h0020,16'h0060,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b01, 4'd4},
        '{'{16'h0060,16'h0020,16'h0020,16'h0020,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b00, 4'd4},
        '{'{16'h0060,16'h0000,16'h0040,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 16'd1000, 2'b00, 4'd6},
        '{'{16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000,16'h0000,16'h0000}, 16'hFFFF, 2'b00, 4'd8},
        '{'{16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000}, 16'd5,    2'b10, 4'd2},
        '{'{16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000}, 16'd6,    2'b10, 4'd4},
        '{'{16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000}, 16'd12,   2'b10, 4'd4},
        '{'{16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000,16'h0040,16'h0000}, 16'd0,    2'b10, 4'd0}
    };
    localparam string VNAME [NV] = '{
        "R3 stable first pair",
        "R12 other bits differ",
        "R4 toggle then stable",
        "R4 flag only in second word",
        "R5 confirm still toggling",
        "R5 confirm stable",
        "R6 confirm clears flag",
        "R8 limit all ones",
        "R9 limit 5",
        "R9 limit 6 strict compare",
        "R9 limit 12 counter from launch",
        "R7 zero limit"
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [TW-1:0] limit_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic [DW-1:0] rd_data_i = '0;
    logic          rd_valid_i = 1'b0;
    logic          busy_o;
    logic          done_o;
    logic [1:0]    result_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    tbit_poller u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .limit_i(limit_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input string nm, input bit inject);
        int nrd = 0;
        int pend = 0;
        int dones = 0;
        int badaddr = 0;
        int cyc = 0;
        int after = 0;
        int got = -1;
        @(negedge clk);
        start_i = 1'b1; addr_i = ADDR; limit_i = v.lim;
        @(negedge clk);
        while (cyc < 600 && after < 4) begin
            rd_valid_i = 1'b0;
            if (inject && cyc == 4) begin
                start_i = 1'b1; addr_i = ALT; limit_i = '0;
            end else begin
                start_i = 1'b0;
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rd_data_i  = v.rd[nrd % 8];
                    rd_valid_i = 1'b1;
                    nrd++;
                end
            end
            if (rd_req_o) begin
                if (rd_addr_o != ADDR) badaddr++;
                pend = 2;
            end
            if (done_o) begin
                dones++;
                got = int'(result_o);
            end
            if (dones > 0) after++;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(got == int'(v.res), {nm, " result"}, got, int'(v.res));
        chk(nrd == int'(v.nrd), {nm, " read count"}, nrd, int'(v.nrd));
        chk(dones == 1, {nm, " R10 done pulses"}, dones, 1);
        chk(badaddr == 0, {nm, " R2 address mismatches"}, badaddr, 0);
        chk(!busy_o, {nm, " idle afterwards"}, int'(busy_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o,   "R1 busy in reset", int'(busy_o), 0);
        chk(!rd_req_o, "R1 req in reset", int'(rd_req_o), 0);
        chk(!done_o,   "R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o && !rd_req_o, "R1 idle after reset", int'(busy_o), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], VNAME[i], 1'b0);
        end

        // R11: start pulse with another address and a zero limit mid-run
        run_vec(VECS[2], "R11 start while busy", 1'b1);

        // R4/R12: flag set in second word and other bits noisy
        run_vec('{'{16'hFF40, 16'h00A0, 16'h1234, 16'h0234, 16'h0, 16'h0, 16'h0, 16'h0},
                  16'd1000, 2'b00, 4'd4}, "R12 noisy upper bits", 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule